// File: doc/BRIEF.md
# Programmable Loop Divider and Phase-Frequency Detector

This block is the digital core of a frequency-synthesizer loop. It accepts two oscillator tick streams, one for the AM band and one for the FM band, each sampled as single-cycle strobes in the system clock domain. Each stream passes through its own fixed prescaler. A band bit picks which prescaled stream clocks a programmable down-counter. The counter divides by the loaded value plus one.

Each terminal count of the counter produces a feedback pulse. A two-flip-flop phase-frequency detector compares this pulse with a reference strobe. A feedback pulse that comes first commands the pump to source current, which means the oscillator is running fast. A reference pulse that comes first commands it to sink current. When both flip-flops are set, the detector clears them, and the pump output is then released to high impedance.

A new divide value or band choice is taken only at a terminal count, so the loop never sees a shortened or stretched period.

Top module: `loop_divider_pfd`

## Requirements
- R1: After reset, `pump_src`, `pump_snk` and `pump_oe` are low, the active band is AM and the count is zero, so the first AM prescaled tick is a terminal count.
- R2: With the AM band active (`band_fm` = 0 adopted), a feedback pulse occurs every AM_PRE*(N+1) ticks of `am_vco_tick`, and `fm_vco_tick` has no effect on that period.
- R3: With the FM band active (`band_fm` = 1 adopted), a feedback pulse occurs every FM_PRE*(N+1) ticks of `fm_vco_tick`, and `am_vco_tick` has no effect on that period.
- R4: N is any value from 0 to 2^CNT_W-1. With N = 0, every selected prescaled tick is a terminal count, and each terminal count reloads the counter with `div_value`.
- R5: `div_value` and `band_fm` are adopted only at a terminal count. The period already running completes at its old length and with its old band.
- R6: A feedback pulse sets `pump_src` one cycle later, and `pump_src` stays high until a clear.
- R7: A high `ref_strobe` sets `pump_snk` one cycle later, and `pump_snk` stays high until a clear.
- R8: `pump_oe` is high exactly when one of `pump_src` and `pump_snk` is high. When both are high, both are cleared on the next cycle.
- R9: `pump_src` and `pump_snk` are never both high for two consecutive cycles, unless a feedback pulse and a reference strobe both arrive during the first of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| am_vco_tick | input | 1 | One-cycle strobe per AM oscillator period |
| fm_vco_tick | input | 1 | One-cycle strobe per FM oscillator period |
| band_fm | input | 1 | Requested band: 1 selects FM, 0 selects AM |
| div_value | input | CNT_W | Requested divide value N; the loop divides by N+1 |
| ref_strobe | input | 1 | Reference comparison strobe |
| pump_src | output | 1 | Command to source pump current (oscillator ahead) |
| pump_snk | output | 1 | Command to sink pump current (oscillator behind) |
| pump_oe | output | 1 | Pump drive enable; low means high impedance |

## Verification
The main instance is built with CNT_W = 5, AM_PRE = 2 and FM_PRE = 3. These small values make it possible to sweep every divide value in both bands, including the N = 0 and all-ones boundaries, in a few thousand cycles each. Holding the reference high turns each feedback pulse into a single-cycle pulse on `pump_src`, so the divided period can be measured at the ports. A second instance keeps the default 14-bit counter and the 8/64 prescale ratios, and is checked at a few divide values to confirm the full-size arithmetic.

// File: rtl/loop_div_pkg.sv
package loop_div_pkg;

  typedef enum logic {BAND_AM = 1'b0, BAND_FM = 1'b1} band_e;

  // Width needed to count 0 .. limit-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

  // Feedback period in prescaled ticks for a loaded value.
  function automatic int unsigned loop_ratio(input int unsigned n);
    return n + 1;
  endfunction

  // Detector flip-flop next state: a new event sets, a clear drops.
  function automatic logic pfd_next(input logic cur, input logic evt, input logic clr);
    return (cur & ~clr) | evt;
  endfunction

endpackage

// File: rtl/loop_div_prescaler.sv
module loop_div_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_out
);
  import loop_div_pkg::*;

  localparam int unsigned W = cnt_width(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase_q;
  logic         wrap;

  generate
    if (DIV <= 1) begin : g_pass
      assign wrap = tick_in;
    end else begin : g_count
      assign wrap = tick_in && (phase_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (tick_in) begin
      phase_q <= wrap ? '0 : phase_q + 1'b1;
    end
  end

  assign tick_out = wrap;

endmodule

// File: rtl/loop_div_counter.sv
module loop_div_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             am_pre,
  input  logic             fm_pre,
  input  logic             band_req,
  input  logic [CNT_W-1:0] n_req,
  output logic             sel_tick,
  output logic             term,
  output logic             band_act,
  output logic [CNT_W-1:0] cnt_q,
  output logic             div_pulse
);
  import loop_div_pkg::*;

  band_e band_q;

  always_comb begin
    sel_tick = (band_q == BAND_FM) ? fm_pre : am_pre;
    term     = sel_tick && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      band_q    <= BAND_AM;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= term;
      if (term) begin
        cnt_q  <= n_req;
        band_q <= band_e'(band_req);
      end else if (sel_tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign band_act = band_q;

endmodule

// File: rtl/loop_div_pfd.sv
module loop_div_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_pulse,
  input  logic ref_pulse,
  output logic up_q,
  output logic dn_q,
  output logic drive_en
);
  import loop_div_pkg::*;

  logic clr;

  assign clr = up_q && dn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= pfd_next(up_q, fb_pulse, clr);
      dn_q <= pfd_next(dn_q, ref_pulse, clr);
    end
  end

  assign drive_en = up_q ^ dn_q;

endmodule

// File: rtl/loop_divider_pfd.sv
module loop_divider_pfd #(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned AM_PRE = 8,
  parameter int unsigned FM_PRE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             am_vco_tick,
  input  logic             fm_vco_tick,
  input  logic             band_fm,
  input  logic [CNT_W-1:0] div_value,
  input  logic             ref_strobe,
  output logic             pump_src,
  output logic             pump_snk,
  output logic             pump_oe
);

  logic             am_pre;
  logic             fm_pre;
  logic             sel_tick;
  logic             term;
  logic             band_act;
  logic [CNT_W-1:0] cnt_q;
  logic             div_pulse;

  loop_div_prescaler #(.DIV(AM_PRE)) u_pre_am (
    .clk(clk), .rst_n(rst_n), .tick_in(am_vco_tick), .tick_out(am_pre)
  );

  loop_div_prescaler #(.DIV(FM_PRE)) u_pre_fm (
    .clk(clk), .rst_n(rst_n), .tick_in(fm_vco_tick), .tick_out(fm_pre)
  );

  loop_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .am_pre(am_pre), .fm_pre(fm_pre),
    .band_req(band_fm), .n_req(div_value), .sel_tick(sel_tick),
    .term(term), .band_act(band_act), .cnt_q(cnt_q), .div_pulse(div_pulse)
  );

  loop_div_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .fb_pulse(div_pulse), .ref_pulse(ref_strobe),
    .up_q(pump_src), .dn_q(pump_snk), .drive_en(pump_oe)
  );

endmodule

// File: rtl/loop_divider_pfd_chk.sv
module loop_divider_pfd_chk #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_pulse,
  input logic             ref_strobe,
  input logic             pump_src,
  input logic             pump_snk,
  input logic             sel_tick,
  input logic             term,
  input logic             band_act,
  input logic             band_fm,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] div_value
);

  p_src_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> pump_src);

  p_src_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_src && !pump_snk && !ref_strobe) |=> pump_src);

  p_snk_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_strobe |=> pump_snk);

  p_both_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_src && pump_snk) |=> (!(pump_src && pump_snk) || $past(div_pulse && ref_strobe)));

  p_band_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(band_act));

  p_band_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (band_act == $past(band_fm)));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (cnt_q == $past(div_value)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tick && !term) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

endmodule

bind loop_divider_pfd loop_divider_pfd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_pulse(div_pulse), .ref_strobe(ref_strobe),
  .pump_src(pump_src), .pump_snk(pump_snk), .sel_tick(sel_tick), .term(term),
  .band_act(band_act), .band_fm(band_fm), .cnt_q(cnt_q), .div_value(div_value)
);

// File: tb/loop_divider_pfd_tb.sv
`timescale 1ns/1ps
module loop_divider_pfd_tb;

  localparam int SW = 5;
  localparam int SAM = 2;
  localparam int SFM = 3;
  localparam int FW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic am_tick = 1'b0, fm_tick = 1'b0;
  logic ref_strobe = 1'b0;
  logic band_s = 1'b0, band_f = 1'b0;
  logic [SW-1:0] n_s = '0;
  logic [FW-1:0] n_f = '0;
  logic src_s, snk_s, oe_s, src_f, snk_f, oe_f;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit am_en = 1'b0, fm_en = 1'b0;
  int am_gap = 1, fm_gap = 1;
  int tcount = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  loop_divider_pfd #(.CNT_W(SW), .AM_PRE(SAM), .FM_PRE(SFM)) u_dut (
    .clk(clk), .rst_n(rst_n), .am_vco_tick(am_tick), .fm_vco_tick(fm_tick),
    .band_fm(band_s), .div_value(n_s), .ref_strobe(ref_strobe),
    .pump_src(src_s), .pump_snk(snk_s), .pump_oe(oe_s)
  );

  loop_divider_pfd u_dut_full (
    .clk(clk), .rst_n(rst_n), .am_vco_tick(am_tick), .fm_vco_tick(fm_tick),
    .band_fm(band_f), .div_value(n_f), .ref_strobe(ref_strobe),
    .pump_src(src_f), .pump_snk(snk_f), .pump_oe(oe_f)
  );

  // oscillator tick generator
  initial begin
    forever begin
      @(negedge clk);
      tcount++;
      am_tick = am_en && (tcount % am_gap == 0);
      fm_tick = fm_en && (tcount % fm_gap == 0);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(input bit full, output int t);
    bit prev, cur;
    prev = full ? src_f : src_s;
    t = -1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      cur = full ? src_f : src_s;
      if (cur && !prev) begin
        t = cyc;
        break;
      end
      prev = cur;
    end
  endtask

  // skip transitional periods, then measure one steady interval
  task automatic measure(input bit full, input int exp, input string tag);
    int t0, t1;
    for (int i = 0; i < 3; i++) wait_rise(full, t0);
    wait_rise(full, t1);
    check(tag, t1 - t0, exp);
  endtask

  function automatic int cycles_per_pulse(input int gap, input int pre, input int n);
    int ticks;
    ticks = pre;
    for (int i = 0; i < n; i++) ticks += pre;
    return gap * ticks;
  endfunction

  initial begin
    int t0, t1, t2, k;
    n_s = 5'd31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 src", src_s, 0);
    check("R1 snk", snk_s, 0);
    check("R1 oe", oe_s, 0);
    check("R1 full oe", oe_f, 0);

    // reference first: sink
    ref_strobe = 1'b1;
    @(negedge clk);
    ref_strobe = 1'b0;
    check("R7 snk set", snk_s, 1);
    check("R7 src idle", src_s, 0);
    check("R8 oe one side", oe_s, 1);
    repeat (3) @(negedge clk);
    check("R7 snk hold", snk_s, 1);

    // feedback arrives: both set then clear
    am_gap = 1;
    am_en = 1'b1;
    k = 0;
    while (!src_s && k < 200) begin @(negedge clk); k++; end
    check("R1 first AM terminal", src_s, 1);
    check("R8 both snk", snk_s, 1);
    check("R8 both oe", oe_s, 0);
    @(negedge clk);
    check("R9 clear src", src_s, 0);
    check("R9 clear snk", snk_s, 0);
    check("R8 idle oe", oe_s, 0);

    // feedback first: source
    k = 0;
    while (!src_s && k < 200) begin @(negedge clk); k++; end
    check("R6 src set", src_s, 1);
    check("R6 snk idle", snk_s, 0);
    check("R8 oe src", oe_s, 1);
    repeat (10) @(negedge clk);
    check("R6 src hold", src_s, 1);
    ref_strobe = 1'b1;
    @(negedge clk);
    ref_strobe = 1'b0;
    check("R8 both after ref", src_s & snk_s, 1);
    @(negedge clk);
    check("R8 cleared", src_s | snk_s | oe_s, 0);

    // period sweeps with reference held high
    ref_strobe = 1'b1;
    am_gap = 2;
    fm_gap = 1;
    fm_en = 1'b1;
    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n < 32; n++) begin
        string tag;
        band_s = b[0];
        n_s = n[SW-1:0];
        if (n == 0 || n == 31) tag = (b == 1) ? "R4 R3 edge" : "R4 R2 edge";
        else tag = (b == 1) ? "R3 FM period" : "R2 AM period";
        measure(1'b0, (b == 1) ? cycles_per_pulse(fm_gap, SFM, n)
                               : cycles_per_pulse(am_gap, SAM, n), tag);
      end
    end

    // R5 adoption of a new value at terminal count
    band_s = 1'b0;
    n_s = 5'd5;
    measure(1'b0, cycles_per_pulse(2, SAM, 5), "R2 setup");
    wait_rise(1'b0, t0);
    n_s = 5'd20;
    wait_rise(1'b0, t1);
    check("R5 old value kept", t1 - t0, cycles_per_pulse(2, SAM, 5));
    wait_rise(1'b0, t2);
    check("R5 new value taken", t2 - t1, cycles_per_pulse(2, SAM, 20));

    // R5 adoption of a band change at terminal count
    wait_rise(1'b0, t0);
    band_s = 1'b1;
    wait_rise(1'b0, t1);
    check("R5 old band kept", t1 - t0, cycles_per_pulse(2, SAM, 20));
    measure(1'b0, cycles_per_pulse(1, SFM, 20), "R5 R3 new band");

    // full-size instance
    band_f = 1'b0;
    n_f = 14'd0;
    measure(1'b1, cycles_per_pulse(am_gap, 8, 0), "R4 R2 full N=0");
    n_f = 14'd100;
    measure(1'b1, cycles_per_pulse(am_gap, 8, 100), "R2 full AM");
    band_f = 1'b1;
    n_f = 14'd3;
    measure(1'b1, cycles_per_pulse(fm_gap, 64, 3), "R3 full FM");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule